// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Underrun Fill

This block turns host-written characters into a continuous synchronous bit stream on a single serial output. A host writes a character into a one-deep holding register. A separate shift register serializes the previous character. This gives one full character time for the host to supply the next one. Characters are 5 to 8 bits long, go out least significant bit first, and may carry a trailing odd or even parity bit. No start, stop or gap bits are ever inserted.

The stream must never pause once it has begun. If the holding register is empty when a character ends, the block sends fill characters on its own. The fill is a single sync character, a pair of two sync characters, or an escape character followed by the first sync character, depending on the mode inputs. It also raises an empty flag. On command, the block places the escape character in front of the next data character. The output advances only on a one-cycle bit strobe. That strobe comes from an external bit-clock generator and marks the falling edge of the transmit clock.

Top module: `sync_serial_tx`

## Requirements
- R1: After enable with no character yet written, `txd` is high and `ready` is high. The stream starts only when the first character has been written.
- R2: A write while enabled drives `ready` low on the next cycle. `ready` returns high on the strobe that moves that character into the shifter.
- R3: A data character has 5, 6, 7 or 8 bits for `len_code` 00, 01, 10 or 11, sent bit 0 first, one bit per strobe. When `par_en` is 1, one parity bit follows. With `par_odd`=0 that bit equals the XOR of the data bits; with `par_odd`=1 it is the inverse. No other bits are sent, and characters follow each other with no idle strobe between them.
- R4: If no character is waiting when a character ends, a fill is sent. The fill is `fill_a` alone when `single_fill`=1 and `transparent`=0. It is `fill_a` then `fill_b` when both mode inputs are 0. It is `esc_char` then `fill_a` when `transparent`=1, whatever `single_fill` is. Both characters of a pair are sent before a waiting data character.
- R5: `empty` rises on the strobe that starts a fill and falls on the cycle after a write. It never rises before the first data character has been sent.
- R6: If `send_esc` is 1 when a waiting data character would be taken, `esc_char` is sent first, and the data character follows directly after it. `ready` stays low until the data character itself is taken.
- R7: If `tx_en` goes low or `cts_n` goes high, the character in the shifter is finished. After that, `txd` stays high.
- R8: While `tx_en` is low, `ready` and `empty` are low and writes are ignored. A waiting character is discarded, and the next enable starts again as in R1.
- R9: `txd` changes only on the cycle after one in which `bit_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle bit strobe |
| tx_en | input | 1 | Transmitter enable |
| cts_n | input | 1 | Clear to send, active low |
| len_code | input | 2 | Character length code |
| par_en | input | 1 | Append parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| single_fill | input | 1 | 1 = one-character sync fill |
| transparent | input | 1 | 1 = escape-plus-sync fill |
| fill_a | input | 8 | First sync character |
| fill_b | input | 8 | Second sync character |
| esc_char | input | 8 | Escape character |
| send_esc | input | 1 | Prefix next data character with escape |
| wr_en | input | 1 | Holding register write |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output |
| ready | output | 1 | Holding register can accept a character |
| empty | output | 1 | Fill in progress since last write |

## Verification
Directed runs cover four situations. The first is the quiet interval after enable. The second is a single write followed by a long underrun, done once in each of the three fill modes; this separates single fills, sync pairs and escape pairs, and shows whether a pair is broken by new data. The third is an escape-prefixed write. The last is a stop in mid-character, made once through clear-to-send and once through disable. Random phases then vary three things: the write density (dense, medium or sparse), the character length and the parity. Dense writes stress back-to-back buffering, sparse writes keep the fill logic busy, and the length and parity changes expose a wrong bit count or parity sense. A bit-level model in the bench predicts every output bit.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
  // Source of the next character loaded into the shifter
  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_DATA  = 3'd1,
    SRC_ESC   = 3'd2,
    SRC_FILL1 = 3'd3,
    SRC_FILL2 = 3'd4
  } tx_src_e;
endpackage

// File: rtl/sync_tx_hold.sv
module sync_tx_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              take,
  output logic              hold_valid,
  output logic [CHAR_W-1:0] hold_data,
  output logic              ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (!tx_en) begin
      hold_valid <= 1'b0;
    end else if (wr_en) begin
      hold_valid <= 1'b1;
      hold_data  <= wr_data;
    end else if (take) begin
      hold_valid <= 1'b0;
    end
  end

  assign ready = tx_en & ~hold_valid;
endmodule

// File: rtl/sync_tx_select.sv
module sync_tx_select
  import sync_tx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic              single_fill,
  input  logic              transparent,
  input  logic [CHAR_W-1:0] fill_a,
  input  logic [CHAR_W-1:0] fill_b,
  input  logic [CHAR_W-1:0] esc_char,
  input  logic              send_esc,
  input  logic              wr_en,
  input  logic              hold_valid,
  input  logic [CHAR_W-1:0] hold_data,
  output logic              load,
  output logic [CHAR_W-1:0] load_char,
  output logic              take,
  output logic              empty,
  output logic              started_o,
  output logic              empty_q_o
);
  logic              started, esc_done, f2_valid, empty_q;
  logic [CHAR_W-1:0] f2_char;
  logic              run;
  tx_src_e           src;

  assign run = tx_en & ~cts_n;

  always_comb begin
    src = SRC_NONE;
    if (boundary && run) begin
      if (f2_valid)                              src = SRC_FILL2;
      else if (hold_valid && send_esc && !esc_done) src = SRC_ESC;
      else if (hold_valid)                       src = SRC_DATA;
      else if (started)                          src = SRC_FILL1;
    end
  end

  always_comb begin
    case (src)
      SRC_FILL2: load_char = f2_char;
      SRC_ESC:   load_char = esc_char;
      SRC_DATA:  load_char = hold_data;
      SRC_FILL1: load_char = transparent ? esc_char : fill_a;
      default:   load_char = '0;
    endcase
  end

  assign load = (src != SRC_NONE);
  assign take = (src == SRC_DATA);

  always_ff @(posedge clk) begin
    if (rst || !tx_en) begin
      started  <= 1'b0;
      esc_done <= 1'b0;
      f2_valid <= 1'b0;
      f2_char  <= '0;
      empty_q  <= 1'b0;
    end else begin
      if (boundary && !run) f2_valid <= 1'b0;
      case (src)
        SRC_FILL2: f2_valid <= 1'b0;
        SRC_ESC:   esc_done <= 1'b1;
        SRC_DATA: begin
          started  <= 1'b1;
          esc_done <= 1'b0;
        end
        SRC_FILL1: begin
          empty_q <= 1'b1;
          if (transparent) begin
            f2_valid <= 1'b1;
            f2_char  <= fill_a;
          end else if (!single_fill) begin
            f2_valid <= 1'b1;
            f2_char  <= fill_b;
          end
        end
        default: ;
      endcase
      if (wr_en) empty_q <= 1'b0;
    end
  end

  assign empty     = tx_en & empty_q;
  assign started_o = started;
  assign empty_q_o = empty_q;
endmodule

// File: rtl/sync_tx_shift.sv
module sync_tx_shift #(
  parameter int CHAR_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_char,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              txd,
  output logic              idle
);
  localparam int FRAME_W = CHAR_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int MIN_LEN = CHAR_W - (1 << LEN_W) + 1;

  logic [FRAME_W-1:0] frame, sh;
  logic [CNT_W-1:0]   len, nbits, cnt;
  logic               par;

  assign len   = CNT_W'(MIN_LEN) + CNT_W'(len_code);
  assign nbits = len + CNT_W'(par_en);

  always_comb begin
    frame = '0;
    par   = par_odd;
    for (int i = 0; i < CHAR_W; i++) begin
      if (CNT_W'(i) < len) begin
        frame[i] = load_char[i];
        par      = par ^ load_char[i];
      end
    end
    for (int i = 0; i < FRAME_W; i++) begin
      if (par_en && CNT_W'(i) == len) frame[i] = par;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd <= 1'b1;
      sh  <= '0;
      cnt <= '0;
    end else if (bit_stb) begin
      if (load) begin
        txd <= frame[0];
        sh  <= frame >> 1;
        cnt <= nbits - 1'b1;
      end else if (cnt != '0) begin
        txd <= sh[0];
        sh  <= sh >> 1;
        cnt <= cnt - 1'b1;
      end else begin
        txd <= 1'b1;
      end
    end
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx #(
  parameter int CHAR_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              tx_en,
  input  logic              cts_n,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              single_fill,
  input  logic              transparent,
  input  logic [CHAR_W-1:0] fill_a,
  input  logic [CHAR_W-1:0] fill_b,
  input  logic [CHAR_W-1:0] esc_char,
  input  logic              send_esc,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              txd,
  output logic              ready,
  output logic              empty
);
  logic              hold_valid, take, load, sh_idle, boundary;
  logic [CHAR_W-1:0] hold_data, load_char;
  logic              started_w, empty_q_w;

  assign boundary = bit_stb & sh_idle;

  sync_tx_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .hold_valid(hold_valid), .hold_data(hold_data), .ready(ready)
  );

  sync_tx_select #(.CHAR_W(CHAR_W)) u_sel (
    .clk(clk), .rst(rst), .boundary(boundary), .tx_en(tx_en), .cts_n(cts_n),
    .single_fill(single_fill), .transparent(transparent), .fill_a(fill_a),
    .fill_b(fill_b), .esc_char(esc_char), .send_esc(send_esc), .wr_en(wr_en),
    .hold_valid(hold_valid), .hold_data(hold_data), .load(load),
    .load_char(load_char), .take(take), .empty(empty),
    .started_o(started_w), .empty_q_o(empty_q_w)
  );

  sync_tx_shift #(.CHAR_W(CHAR_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .load(load), .load_char(load_char),
    .len_code(len_code), .par_en(par_en), .par_odd(par_odd),
    .txd(txd), .idle(sh_idle)
  );
endmodule

// File: rtl/sync_tx_chk.sv
module sync_tx_chk (
  input logic clk,
  input logic rst,
  input logic bit_stb,
  input logic tx_en,
  input logic wr_en,
  input logic txd,
  input logic ready,
  input logic sel_empty,
  input logic sel_started
);
  // R2: an accepted write blocks ready on the next cycle
  a_r2_write_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (tx_en && wr_en) |=> !ready);

  // R2: ready falls only through a write or a disable
  a_r2_ready_fall_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> (!tx_en || $past(wr_en)));

  // R9: serial output moves only after a strobe
  a_r9_txd_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(txd));

  // R8: disabling clears the fill and start state
  a_r8_off_clears: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!sel_empty && !sel_started));

  // R5: empty never precedes the first data character
  a_r5_empty_after_start: assert property (@(posedge clk) disable iff (rst)
    sel_empty |-> sel_started);
endmodule

bind sync_serial_tx sync_tx_chk u_chk (
  .clk(clk), .rst(rst), .bit_stb(bit_stb), .tx_en(tx_en), .wr_en(wr_en),
  .txd(txd), .ready(ready), .sel_empty(empty_q_w), .sel_started(started_w)
);

// File: tb/sync_serial_tx_bench.sv
`timescale 1ns/1ps
module sync_serial_tx_bench;
  logic       clk = 1'b0, rst = 1'b1, bit_stb = 1'b0, tx_en = 1'b0, cts_n = 1'b0;
  logic [1:0] len_code = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, single_fill = 1'b1, transparent = 1'b0;
  logic [7:0] fill_a = 8'h16, fill_b = 8'h26, esc_char = 8'h10;
  logic       send_esc = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, ready, empty;

  always #2.5 clk = ~clk;

  sync_serial_tx u_sync_serial_tx (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .tx_en(tx_en), .cts_n(cts_n),
    .len_code(len_code), .par_en(par_en), .par_odd(par_odd),
    .single_fill(single_fill), .transparent(transparent), .fill_a(fill_a),
    .fill_b(fill_b), .esc_char(esc_char), .send_esc(send_esc), .wr_en(wr_en),
    .wr_data(wr_data), .txd(txd), .ready(ready), .empty(empty)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit m_hv = 0, m_started = 0, m_f2v = 0, m_escd = 0, m_empty = 0;
  logic [7:0] m_hd = '0, m_f2c = '0;
  logic [8:0] m_sh = '0;
  int m_cnt = 0;
  logic m_txd = 1'b1;
  string m_tag = "R1";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void mk_frame(input logic [7:0] ch, output logic [8:0] f, output int nb);
    int len, ones;
    len = 5 + int'(len_code);
    ones = 0;
    f = '0;
    for (int i = 0; i < len; i++) begin
      f[i] = ch[i];
      if (ch[i]) ones++;
    end
    nb = len;
    if (par_en) begin
      f[len] = par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
      nb++;
    end
  endfunction

  task automatic model_strobe();
    logic [7:0] ch;
    logic [8:0] f;
    int nb;
    bit got;
    bit run;
    run = tx_en && !cts_n;
    got = 0;
    ch = '0;
    if (m_cnt > 0) begin
      m_txd = m_sh[0];
      m_sh = m_sh >> 1;
      m_cnt--;
    end else if (!run) begin
      m_txd = 1'b1;
      m_f2v = 0;
      m_tag = "R7";
    end else begin
      if (m_f2v) begin
        ch = m_f2c; m_f2v = 0; m_tag = "R4"; got = 1;
      end else if (m_hv && send_esc && !m_escd) begin
        ch = esc_char; m_escd = 1; m_tag = "R6"; got = 1;
      end else if (m_hv) begin
        ch = m_hd; m_hv = 0; m_started = 1; m_escd = 0; m_tag = "R3"; got = 1;
      end else if (m_started) begin
        m_empty = 1; m_tag = "R4"; got = 1;
        if (transparent) begin
          ch = esc_char; m_f2v = 1; m_f2c = fill_a;
        end else begin
          ch = fill_a;
          if (!single_fill) begin m_f2v = 1; m_f2c = fill_b; end
        end
      end
      if (got) begin
        mk_frame(ch, f, nb);
        m_txd = f[0];
        m_sh = f >> 1;
        m_cnt = nb - 1;
      end else begin
        m_txd = 1'b1;
        m_tag = "R1";
      end
    end
  endtask

  // one slot: optional write, then one strobe, with checks
  task automatic slot(input bit do_wr, input logic [7:0] d);
    @(negedge clk);
    if (!tx_en) begin
      m_hv = 0; m_started = 0; m_empty = 0; m_escd = 0; m_f2v = 0;
    end
    wr_en = do_wr;
    wr_data = d;
    if (do_wr && tx_en) begin
      m_hv = 1; m_hd = d; m_empty = 0;
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(txd === m_txd, "R9", 32'(txd), 32'(m_txd));
    if (do_wr) chk(ready === 1'b0, tx_en ? "R2" : "R8", 32'(ready), 0);
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    model_strobe();
    @(negedge clk);
    chk(txd === m_txd, m_tag, 32'(txd), 32'(m_txd));
    chk(ready === (tx_en && !m_hv), tx_en ? "R2" : "R8", 32'(ready), 32'(tx_en && !m_hv));
    chk(empty === (tx_en && m_empty), tx_en ? "R5" : "R8", 32'(empty), 32'(tx_en && m_empty));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired act=%0d exp=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R1", 32'(txd), 1);
    chk(ready === 1'b0, "R8", 32'(ready), 0);
    chk(empty === 1'b0, "R8", 32'(empty), 0);

    // R1: enabled, nothing written
    tx_en = 1'b1;
    repeat (6) slot(0, 8'h00);
    // R4 single fill after one character
    slot(1, 8'hA5);
    repeat (30) slot(0, 8'h00);
    // R4 double fill, then data arriving mid-pair
    single_fill = 1'b0;
    slot(1, 8'h3C);
    repeat (20) slot(0, 8'h00);
    slot(1, 8'h81);
    repeat (20) slot(0, 8'h00);
    // R4 transparent fill; R6 escape prefix, with parity (R3)
    transparent = 1'b1;
    par_en = 1'b1;
    repeat (12) slot(0, 8'h00);
    send_esc = 1'b1;
    slot(1, 8'h5A);
    repeat (4) slot(0, 8'h00);
    send_esc = 1'b0;
    repeat (20) slot(0, 8'h00);
    // R7: clear-to-send removed mid character, then restored
    transparent = 1'b0;
    slot(1, 8'hF0);
    repeat (3) slot(0, 8'h00);
    cts_n = 1'b1;
    repeat (15) slot(0, 8'h00);
    cts_n = 1'b0;
    repeat (15) slot(0, 8'h00);
    // R7 and R8: disable mid character, writes ignored while off
    slot(1, 8'h0F);
    repeat (12) slot(0, 8'h00);
    tx_en = 1'b0;
    repeat (4) slot(0, 8'h00);
    slot(1, 8'hEE);
    repeat (12) slot(0, 8'h00);
    tx_en = 1'b1;
    repeat (6) slot(0, 8'h00);

    // random phases: dense, medium, sparse writes
    for (int ph = 0; ph < 3; ph++) begin
      int pct;
      pct = (ph == 0) ? 80 : (ph == 1) ? 30 : 6;
      fill_a = 8'($urandom); fill_b = 8'($urandom); esc_char = 8'($urandom);
      for (int s = 0; s < 1500; s++) begin
        if (($urandom % 50) == 0) begin
          len_code = 2'($urandom); par_en = 1'($urandom); par_odd = 1'($urandom);
          single_fill = 1'($urandom); transparent = (($urandom % 3) == 0);
        end
        if (($urandom % 60) == 0) tx_en = ~tx_en;
        if (($urandom % 45) == 0) cts_n = ~cts_n;
        send_esc = (($urandom % 10) == 0);
        slot((($urandom % 100) < pct), 8'($urandom));
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule